// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst inside a synchronous burst memory. An access starts when one of two active-low address strobes is sampled on a rising clock edge. One strobe belongs to a processor and the other to a cache controller. On that edge the block captures the full incoming word address. The two low bits become the burst base, the upper bits are held for the whole burst, and an internal beat count restarts at zero.

Each later edge with the advance input high moves the beat count on by one. An edge with advance low holds the current address, which inserts a wait state. The order of the four offsets depends on a mode input, which is registered before it is used:

- Interleaved order: the base XOR the beat count.
- Linear order: the base plus the beat count, wrapping inside the four-word group.

A flag output reports which strobe started the current burst, so that downstream write control can apply the timing that belongs to that strobe.

Top module: `burst_seq_gen`

## Requirements
- R1: A synchronous active-high reset clears the base, the upper bits, the beat count, the registered mode and the source flag. On the edge after reset, `burstOfs` is 0, `wordAddr` is 0 and `procBurst` is 0.
- R2: When `procStrbN` is 0 and `primCeN` is 0 on a rising edge, `wordAddr` equals `addrIn` after that edge and `procBurst` is 1.
- R3: When `ctrlStrbN` is 0 on an edge and the processor strobe is not acted on, `addrIn` is loaded the same way and `procBurst` is 0.
- R4: When both strobes are 0 together with `primCeN` at 0, only the processor strobe is acted on, so `procBurst` is 1 after the edge.
- R5: When `primCeN` is 1, a low `procStrbN` has no effect. With `ctrlStrbN` high, the address and the flag keep their values.
- R6: With no load, `advance` at 1 increments the beat count on the edge. `advance` at 0 holds it.
- R7: With the registered mode at 0 (interleaved), `burstOfs` is base XOR beat.
- R8: With the registered mode at 1 (linear), `burstOfs` is (base + beat) mod 4.
- R9: Beats past the fourth wrap within the same four-word group. `wordAddr[ADDR_W-1:2]` never changes without a load.
- R10: A change on `modeLinear` alters the ordering only from the edge on which the new value is sampled. `burstOfs` therefore follows the mode one cycle late.
- R11: A load on the same edge as `advance` restarts the beat count at 0. The load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addrIn | input | ADDR_W | Word address offered with a strobe |
| procStrbN | input | 1 | Processor address strobe, active low |
| ctrlStrbN | input | 1 | Controller address strobe, active low |
| primCeN | input | 1 | Primary chip enable, active low; qualifies the processor strobe |
| advance | input | 1 | Steps the burst when high |
| modeLinear | input | 1 | 1 selects linear order, 0 selects interleaved order |
| burstOfs | output | 2 | Current two-bit burst offset |
| wordAddr | output | ADDR_W | Upper bits from the load, low bits equal to burstOfs |
| procBurst | output | 1 | 1 when the processor strobe started the current burst |

## Verification
Every output is due exactly one rising edge after the inputs that cause it. Loads, steps, holds and the registered mode all take effect on that edge, so the ordering seen after an edge uses the mode sampled on that same edge. Inputs change shortly after each rising edge. The bench updates its behavioural model on the rising edge from those settled inputs and compares all outputs at the following falling edge, where both the model and the design have absorbed exactly one edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BURST_BITS = 2;

  typedef struct packed {
    logic load;
    logic fromProc;
    logic step;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        procStrbN,
  input  logic        ctrlStrbN,
  input  logic        primCeN,
  input  logic        advance,
  output seqStrobes_t strb
);
  logic procAct;
  logic ctrlAct;

  // processor strobe counts only while the primary enable is active
  assign procAct = ~procStrbN & ~primCeN;
  // controller strobe counts only when the processor strobe is not acted on
  assign ctrlAct = ~ctrlStrbN & ~procAct;

  always_comb begin
    strb.load     = procAct | ctrlAct;
    strb.fromProc = procAct;
    strb.step     = advance & ~(procAct | ctrlAct);
  end
endmodule

// File: rtl/burst_seq_path.sv
module burst_seq_path
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              modeLinear,
  output logic [BURST_BITS-1:0] burstOfs,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              procBurst
);
  localparam int UP_W = ADDR_W - BURST_BITS;

  logic [BURST_BITS-1:0] baseQ;
  logic [BURST_BITS-1:0] beatQ;
  logic [UP_W-1:0]       upperQ;
  logic                  modeQ;
  logic                  procQ;
  logic [BURST_BITS-1:0] ilvOfs;
  logic [BURST_BITS-1:0] linOfs;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ  <= '0;
      beatQ  <= '0;
      upperQ <= '0;
      modeQ  <= 1'b0;
      procQ  <= 1'b0;
    end else begin
      modeQ <= modeLinear;
      if (strb.load) begin
        baseQ  <= addrIn[BURST_BITS-1:0];
        upperQ <= addrIn[ADDR_W-1:BURST_BITS];
        beatQ  <= '0;
        procQ  <= strb.fromProc;
      end else if (strb.step) begin
        beatQ <= beatQ + 1'b1;
      end
    end
  end

  // per-bit interleave, carry-wrapping sum for linear
  for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv
    assign ilvOfs[b] = baseQ[b] ^ beatQ[b];
  end
  assign linOfs = baseQ + beatQ;

  assign burstOfs  = modeQ ? linOfs : ilvOfs;
  assign wordAddr  = {upperQ, burstOfs};
  assign procBurst = procQ;
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrbN,
  input  logic              ctrlStrbN,
  input  logic              primCeN,
  input  logic              advance,
  input  logic              modeLinear,
  output logic [1:0]        burstOfs,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              procBurst
);
  seqStrobes_t strb;

  burst_seq_ctrl u_ctrl (
    .procStrbN (procStrbN),
    .ctrlStrbN (ctrlStrbN),
    .primCeN   (primCeN),
    .advance   (advance),
    .strb      (strb)
  );

  burst_seq_path #(.ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .addrIn     (addrIn),
    .modeLinear (modeLinear),
    .burstOfs   (burstOfs),
    .wordAddr   (wordAddr),
    .procBurst  (procBurst)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrbN,
  input logic              ctrlStrbN,
  input logic              primCeN,
  input logic              advance,
  input logic [1:0]        burstOfs,
  input logic [ADDR_W-1:0] wordAddr,
  input logic              procBurst
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (burstOfs == 2'd0 && wordAddr == '0 && !procBurst));

  // R2
  proc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!procStrbN && !primCeN) |=> (wordAddr == $past(addrIn) && procBurst));

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrlStrbN && (procStrbN || primCeN)) |=> (wordAddr == $past(addrIn) && !procBurst));

  // R4
  proc_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (!procStrbN && !ctrlStrbN && !primCeN) |=> procBurst);

  // R5
  ignored_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (primCeN && ctrlStrbN) |=> $stable(procBurst));

  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((procStrbN || primCeN) && ctrlStrbN) |=> $stable(wordAddr[ADDR_W-1:2]));

  // R11
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrlStrbN && advance) |=> (burstOfs == $past(addrIn[1:0])));
endmodule

bind burst_seq_gen burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addrIn    (addrIn),
  .procStrbN (procStrbN),
  .ctrlStrbN (ctrlStrbN),
  .primCeN   (primCeN),
  .advance   (advance),
  .burstOfs  (burstOfs),
  .wordAddr  (wordAddr),
  .procBurst (procBurst)
);

// File: tb/tb_burst_seq_gen.sv
`timescale 1ns/1ps
module tb_burst_seq_gen;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic          procStrbN = 1'b1;
  logic          ctrlStrbN = 1'b1;
  logic          primCeN = 1'b1;
  logic          advance = 1'b0;
  logic          modeLinear = 1'b0;
  logic [1:0]    burstOfs;
  logic [AW-1:0] wordAddr;
  logic          procBurst;

  always #2.5 clk = ~clk;

  burst_seq_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addrIn(addrIn), .procStrbN(procStrbN),
    .ctrlStrbN(ctrlStrbN), .primCeN(primCeN), .advance(advance),
    .modeLinear(modeLinear), .burstOfs(burstOfs), .wordAddr(wordAddr),
    .procBurst(procBurst)
  );

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;

  // behavioural reference
  int    mBase = 0, mBeat = 0, mUpper = 0, mMode = 0, mProc = 0, mPrevMode = 0;
  string mTag = "R1";

  always @(posedge clk) begin
    started <= 1'b1;
    mPrevMode <= mMode;
    mMode <= modeLinear;
    if (rst) begin
      mBase <= 0; mBeat <= 0; mUpper <= 0; mMode <= 0; mProc <= 0; mTag <= "R1";
    end else if (!procStrbN && !primCeN) begin
      mBase <= addrIn & 3; mUpper <= addrIn >> 2; mBeat <= 0; mProc <= 1;
      mTag <= advance ? "R11" : (!ctrlStrbN ? "R4" : "R2");
    end else if (!ctrlStrbN) begin
      mBase <= addrIn & 3; mUpper <= addrIn >> 2; mBeat <= 0; mProc <= 0;
      mTag <= advance ? "R11" : "R3";
    end else if (advance) begin
      mBeat <= (mBeat + 1) % 4;
      mTag <= (mBeat == 3) ? "R9" : (modeLinear != mMode) ? "R10" : (modeLinear ? "R8" : "R7");
    end else begin
      mTag <= !procStrbN ? "R5" : "R6";
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      int expOfs;
      int expAddr;
      expOfs  = mMode ? ((mBase + mBeat) % 4) : (mBase ^ mBeat);
      expAddr = (mUpper << 2) | expOfs;
      total++;
      if (burstOfs !== expOfs[1:0] || wordAddr !== expAddr[AW-1:0] || procBurst !== mProc[0]) begin
        bad++;
        $display("FAIL %s: ofs=%0d addr=%h src=%0d expected ofs=%0d addr=%h src=%0d",
                 mTag, burstOfs, wordAddr, procBurst, expOfs, expAddr, mProc);
      end
    end
  end

  task automatic drive(input bit p, input bit c, input bit ce, input bit adv,
                       input bit md, input int a);
    @(posedge clk); #1;
    procStrbN = p; ctrlStrbN = c; primCeN = ce; advance = adv;
    modeLinear = md; addrIn = a[AW-1:0];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R2 processor load, interleaved steps R7 and wrap R9
    drive(0, 1, 0, 0, 0, 'h1A5A6);
    for (int i = 0; i < 6; i++) drive(1, 1, 0, 1, 0, 0);
    // R6 wait states
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0);
    // R3 controller load, linear R8
    drive(1, 0, 1, 0, 1, 'h0F3F1);
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 1, 1, 0);
    // R10 mode flip mid burst
    drive(1, 1, 1, 1, 0, 0);
    drive(1, 1, 1, 1, 1, 0);
    // R4 both strobes
    drive(0, 0, 0, 0, 0, 'h05557);
    drive(1, 1, 0, 1, 0, 0);
    // R5 processor strobe ignored
    drive(0, 1, 1, 0, 0, 'h1FFFF);
    drive(0, 1, 1, 0, 0, 'h12340);
    // R3 with processor strobe disqualified, then R11
    drive(0, 0, 1, 0, 1, 'h00402);
    drive(1, 0, 1, 1, 1, 'h00003);
    drive(0, 1, 0, 1, 0, 'h1C001);
    // R1 reset mid burst
    drive(1, 1, 0, 1, 0, 0);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    // random mix
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 5) != 0, ($urandom % 5) != 0, $urandom % 2,
            $urandom % 2, ($urandom % 8) == 0 ? ~modeLinear : modeLinear, $urandom);
    drive(1, 1, 1, 0, modeLinear, 0);
    @(posedge clk); @(negedge clk); #0.5;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule